// File: doc/BRIEF.md
# Pipelined 32-bit Bus Cycle Controller

This block is the bus master side of a demultiplexed 32-bit address and data bus. It takes one internal transfer request at a time and turns it into an external bus cycle. The request carries an address, a byte count of one to four, a direction, and the memory/IO and data/control kinds. The controller works out the active-low byte lane enables and pulses an active-low address strobe for one cycle. It then holds the data phase until an active-low ready input is sampled asserted, and returns one response that carries the read data merged from the enabled lanes.

Three further functions sit in the same state machine:
- **Next-address input.** When this active-low input is sampled asserted during a data phase, the next request's address is put on the bus before the current cycle completes.
- **16-bit sizing input.** When this active-low input is sampled asserted at completion, a transfer with bytes in both 16-bit halves is finished by a second cycle for the upper half.
- **Bus hand-over.** Another master can take the bus through hold / hold-acknowledge. This is allowed only between cycles, and never while a locked sequence is in progress.

Top module: `busctl_top`

## Requirements
- R1: Byte enables `be_n_o` are active low. `req_size` code n (0..3) selects n+1 contiguous lanes starting at lane `req_addr[1:0]`, where lane k is data bits 8k+7..8k. `addr_o` carries `req_addr[31:2]`.
- R2: A request whose `req_addr[1:0] + req_size` exceeds 3 is acknowledged without any bus cycle (`ads_n_o` stays high). The response follows in the next cycle with `resp_err`=1 and `resp_rdata`=0.
- R3: A request acknowledged while idle drives `ads_n_o` low for exactly the next cycle. The data phase follows, and `resp_valid` pulses in the cycle after `rdy_n_i` is sampled low in the data phase.
- R4: While `rdy_n_i` is high in the data phase, wait states are inserted: there is no response, `ads_n_o` is high and the byte enables are unchanged.
- R5: During the strobe, `wr_o`=1 for a write, `dc_o`=1 for a data cycle (0 for control) and `mio_o`=1 for memory (0 for IO), as requested.
- R6: With `nxt_n_i` low and `rdy_n_i` high in a data phase, an aligned pending request is acknowledged at once. Its address is strobed in the next cycle, and its data phase starts right after the current cycle's ready, with no separate address cycle. This happens only if the current transfer has bytes in a single 16-bit half and `hold_i` is low.
- R7: If `sz16_n_i` is low when ready is sampled and the transfer has active bytes in both halves (lanes 0-1 and 2-3), a second cycle is strobed with only the upper lanes enabled. A single response follows the second ready.
- R8: For a read, `resp_rdata` holds `din_i` lanes captured in the cycle whose byte enables covered them, with disabled lanes zero. For a write, `resp_rdata` is zero.
- R9: `hlda_o` rises only between bus cycles, one cycle after `hold_i` is seen while idle and unlocked. Hold takes priority over a request (no acknowledge). While `hlda_o` is high, `bus_oe_o`=0, `dout_oe_o`=0 and `ads_n_o`=1. `hlda_o` falls the cycle after `hold_i` drops.
- R10: `lock_n_o` goes low the cycle after a request with `req_lock`=1 is acknowledged, and goes high after an unlocked request is acknowledged. While it is low, hold is not granted.
- R11: After reset: `ads_n_o`=1, `be_n_o`=4'hF, `hlda_o`=0, `lock_n_o`=1, `resp_valid`=0, `bus_oe_o`=1.
- R12: For a write, `dout_oe_o` is high and `dout_o` equals the write data during the address and data phases. For a read, `dout_oe_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Transfer request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_data | input | 1 | 1 = data cycle, 0 = control cycle |
| req_mem | input | 1 | 1 = memory space, 0 = IO space |
| req_lock | input | 1 | Request belongs to a locked sequence |
| req_addr | input | AW | Byte address |
| req_size | input | 2 | Byte count minus one |
| req_wdata | input | DW | Write data, lane aligned |
| req_ack | output | 1 | Request taken this cycle |
| resp_valid | output | 1 | Transfer finished |
| resp_err | output | 1 | Transfer rejected as misaligned |
| resp_rdata | output | DW | Merged read data |
| addr_o | output | AW-2 | Bus word address |
| be_n_o | output | 4 | Active-low byte lane enables |
| ads_n_o | output | 1 | Active-low address strobe |
| wr_o | output | 1 | Write/read definition |
| dc_o | output | 1 | Data/control definition |
| mio_o | output | 1 | Memory/IO definition |
| lock_n_o | output | 1 | Active-low bus lock |
| bus_oe_o | output | 1 | Drive enable for address, strobe, enables, definitions |
| dout_o | output | DW | Write data to bus |
| dout_oe_o | output | 1 | Drive enable for write data |
| din_i | input | DW | Read data from bus |
| rdy_n_i | input | 1 | Active-low cycle ready |
| nxt_n_i | input | 1 | Active-low next-address request |
| sz16_n_i | input | 1 | Active-low 16-bit device indication |
| hold_i | input | 1 | Bus request from another master |
| hlda_o | output | 1 | Bus granted to the other master |

## Verification
The bench goes after the corner cases below; the notes say what a faulty design would show.
- **Misaligned request one byte past the 4-byte boundary.** A design that checked the bound wrongly would strobe a cycle with enables that wrap into the wrong lanes.
- **16-bit splits, including a two-byte transfer that straddles lanes 1 and 2.** Here a wrong half mask would either skip the second strobe or answer with bytes captured from the wrong cycle.
- **Pipelined address, and its refusal when a split is still possible.** A controller that ignored the refusal rule would emit a new address while the upper half was still owed.
- **Hold against a pending request, and hold during a locked sequence.** An early grant would float the bus in the middle of a locked sequence, and a late one would keep the other master waiting after the unlock.

// File: rtl/busctl_pkg.sv
// Shared types for the bus cycle controller.
package busctl_pkg;
    // Bus cycle state: idle, address strobe, data phase, bus handed over.
    typedef enum logic [1:0] {ST_IDLE, ST_ADDR, ST_DATA, ST_HOLD} bc_state_t;

    // Cycle definition carried with an address phase.
    typedef struct packed {
        logic wr;
        logic dc;
        logic mio;
    } bc_kind_t;
endpackage

// File: rtl/busctl_lanes.sv
// Byte lane enable generator.
// Turns a lane offset and a byte count minus one into a contiguous enable
// mask, and flags a request whose last byte falls past the last lane.
// Assumes NL is a power of two.
module busctl_lanes #(
    parameter int NL = 4,
    localparam int OW = $clog2(NL)
) (
    input  logic [OW-1:0] offs,
    input  logic [OW-1:0] size,
    output logic [NL-1:0] be,
    output logic          misal
);
    logic [OW:0] last;

    // Index of the last byte touched by the request.
    assign last  = {1'b0, offs} + {1'b0, size};
    assign misal = last > (OW+1)'(NL-1);

    // One enable per lane: active when the lane lies in [offs, last].
    for (genvar i = 0; i < NL; i++) begin : g_lane
        assign be[i] = ((OW+1)'(i) >= {1'b0, offs}) && ((OW+1)'(i) <= last);
    end
endmodule

// File: rtl/busctl_rdmerge.sv
// Read lane merger.
// Replaces the accumulated byte of each lane selected by 'take' with the
// byte arriving from the bus; other lanes keep the accumulated value.
module busctl_rdmerge #(
    parameter int NL = 4
) (
    input  logic [8*NL-1:0] acc,
    input  logic [8*NL-1:0] din,
    input  logic [NL-1:0]   take,
    output logic [8*NL-1:0] merged
);
    // Per-lane select between bus byte and held byte.
    for (genvar i = 0; i < NL; i++) begin : g_merge
        assign merged[8*i +: 8] = take[i] ? din[8*i +: 8] : acc[8*i +: 8];
    end
endmodule

// File: rtl/busctl_top.sv
// Bus cycle controller top.
// Runs one request at a time through address strobe and data phase, with
// wait states, next-address pipelining, 16-bit splitting and hold/lock
// arbitration. Assumes DW = 32 (four lanes, two halves) and that the
// request fields stay stable while req_valid is high and not acknowledged.
module busctl_top
    import busctl_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32,
    localparam int NL = DW / 8,
    localparam int OW = $clog2(NL)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic          req_data,
    input  logic          req_mem,
    input  logic          req_lock,
    input  logic [AW-1:0] req_addr,
    input  logic [OW-1:0] req_size,
    input  logic [DW-1:0] req_wdata,
    output logic          req_ack,
    output logic          resp_valid,
    output logic          resp_err,
    output logic [DW-1:0] resp_rdata,
    output logic [AW-3:0] addr_o,
    output logic [NL-1:0] be_n_o,
    output logic          ads_n_o,
    output logic          wr_o,
    output logic          dc_o,
    output logic          mio_o,
    output logic          lock_n_o,
    output logic          bus_oe_o,
    output logic [DW-1:0] dout_o,
    output logic          dout_oe_o,
    input  logic [DW-1:0] din_i,
    input  logic          rdy_n_i,
    input  logic          nxt_n_i,
    input  logic          sz16_n_i,
    input  logic          hold_i,
    output logic          hlda_o
);
    localparam int HALF = NL / 2;

    bc_state_t     state;
    logic [AW-3:0] a_addr;
    logic [NL-1:0] a_be;
    bc_kind_t      a_kind;
    logic          pipe_ads;
    logic          pipe;
    logic [DW-1:0] nx_wdata;
    logic          d_wr;
    logic [NL-1:0] d_be;
    logic [DW-1:0] d_wdata;
    logic          d_upper;
    logic          locked;
    logic [DW-1:0] rdbuf;

    logic [NL-1:0] req_be;
    logic          req_misal;
    logic [DW-1:0] merged;
    logic          hold_ok, idle_acc, pipe_acc, split_risk, done_edge, split_go;
    bc_kind_t      req_kind;

    busctl_lanes #(.NL(NL)) u_lanes (
        .offs  (req_addr[OW-1:0]),
        .size  (req_size),
        .be    (req_be),
        .misal (req_misal)
    );

    busctl_rdmerge #(.NL(NL)) u_merge (
        .acc    (rdbuf),
        .din    (din_i),
        .take   (d_wr ? '0 : d_be),
        .merged (merged)
    );

    // Acceptance, split and completion decisions for this cycle.
    always_comb begin
        req_kind   = '{wr: req_write, dc: req_data, mio: req_mem};
        hold_ok    = hold_i && !locked;
        split_risk = (|d_be[HALF-1:0]) && (|d_be[NL-1:HALF]) && !d_upper;
        idle_acc   = (state == ST_IDLE) && req_valid && !hold_ok;
        pipe_acc   = (state == ST_DATA) && req_valid && !req_misal && !nxt_n_i
                     && rdy_n_i && !pipe && !split_risk && !hold_i;
        req_ack    = idle_acc || pipe_acc;
        done_edge  = (state == ST_DATA) && !rdy_n_i;
        split_go   = done_edge && !sz16_n_i && split_risk;
    end

    // Bus-facing outputs derived from the registered phase state.
    always_comb begin
        addr_o    = a_addr;
        be_n_o    = ~a_be;
        wr_o      = a_kind.wr;
        dc_o      = a_kind.dc;
        mio_o     = a_kind.mio;
        ads_n_o   = !((state == ST_ADDR) || pipe_ads);
        hlda_o    = (state == ST_HOLD);
        bus_oe_o  = (state != ST_HOLD);
        lock_n_o  = !locked;
        dout_o    = d_wdata;
        dout_oe_o = d_wr && ((state == ST_ADDR) || (state == ST_DATA));
    end

    // Cycle state machine with phase registers and response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            a_addr     <= '0;
            a_be       <= '0;
            a_kind     <= '0;
            pipe_ads   <= 1'b0;
            pipe       <= 1'b0;
            nx_wdata   <= '0;
            d_wr       <= 1'b0;
            d_be       <= '0;
            d_wdata    <= '0;
            d_upper    <= 1'b0;
            locked     <= 1'b0;
            rdbuf      <= '0;
            resp_valid <= 1'b0;
            resp_err   <= 1'b0;
            resp_rdata <= '0;
        end else begin
            resp_valid <= 1'b0;
            resp_err   <= 1'b0;
            pipe_ads   <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (hold_ok) begin
                        state <= ST_HOLD;
                    end else if (req_valid) begin
                        if (req_misal) begin
                            resp_valid <= 1'b1;
                            resp_err   <= 1'b1;
                            resp_rdata <= '0;
                        end else begin
                            a_addr  <= req_addr[AW-1:2];
                            a_be    <= req_be;
                            a_kind  <= req_kind;
                            d_wr    <= req_write;
                            d_be    <= req_be;
                            d_wdata <= req_wdata;
                            d_upper <= 1'b0;
                            locked  <= req_lock;
                            state   <= ST_ADDR;
                        end
                    end
                end
                ST_ADDR: state <= ST_DATA;
                ST_DATA: begin
                    if (split_go) begin
                        a_be    <= {d_be[NL-1:HALF], {HALF{1'b0}}};
                        d_be    <= {d_be[NL-1:HALF], {HALF{1'b0}}};
                        d_upper <= 1'b1;
                        rdbuf   <= merged;
                        state   <= ST_ADDR;
                    end else if (done_edge) begin
                        resp_valid <= 1'b1;
                        resp_rdata <= merged;
                        rdbuf      <= '0;
                        if (pipe) begin
                            pipe    <= 1'b0;
                            d_wr    <= a_kind.wr;
                            d_be    <= a_be;
                            d_wdata <= nx_wdata;
                            d_upper <= 1'b0;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                    if (pipe_acc) begin
                        a_addr   <= req_addr[AW-1:2];
                        a_be     <= req_be;
                        a_kind   <= req_kind;
                        nx_wdata <= req_wdata;
                        locked   <= req_lock;
                        pipe     <= 1'b1;
                        pipe_ads <= 1'b1;
                    end
                end
                ST_HOLD: if (!hold_i) state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/busctl_chk.sv
// Property checker for the bus cycle controller, bound to busctl_top.
// Observes ports only; all properties are disabled during reset.
module busctl_chk #(
    parameter int NL = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_ack,
    input logic          resp_valid,
    input logic          resp_err,
    input logic [NL-1:0] be_n_o,
    input logic          ads_n_o,
    input logic          lock_n_o,
    input logic          bus_oe_o,
    input logic          dout_oe_o,
    input logic          rdy_n_i,
    input logic          hlda_o
);
    // Strobe lasts exactly one cycle.
    assert_strobe_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !ads_n_o |=> ads_n_o);

    // A strobed cycle enables at least one lane.
    assert_strobe_has_lane_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !ads_n_o |-> (be_n_o != {NL{1'b1}}));

    // Good completion only follows a sampled ready.
    assert_resp_after_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_err) |-> $past(!rdy_n_i));

    // Error response follows the acknowledge of the rejected request.
    assert_err_after_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
        resp_err |-> $past(req_ack));

    // Granted bus is fully released.
    assert_hold_floats_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hlda_o |-> (!bus_oe_o && !dout_oe_o && ads_n_o));

    // Grant never starts right after a strobe.
    assert_hold_between_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hlda_o) |-> $past(ads_n_o));

    // No grant during a locked sequence.
    assert_no_hold_locked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        hlda_o |-> lock_n_o);
endmodule

bind busctl_top busctl_chk #(.NL(NL)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ack    (req_ack),
    .resp_valid (resp_valid),
    .resp_err   (resp_err),
    .be_n_o     (be_n_o),
    .ads_n_o    (ads_n_o),
    .lock_n_o   (lock_n_o),
    .bus_oe_o   (bus_oe_o),
    .dout_oe_o  (dout_oe_o),
    .rdy_n_i    (rdy_n_i),
    .hlda_o     (hlda_o)
);

// File: tb/busctl_top_tb.sv
`timescale 1ns/1ps
module busctl_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_data = 1'b1, req_mem = 1'b1, req_lock = 1'b0;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic [31:0] req_wdata = '0;
    logic        req_ack, resp_valid, resp_err;
    logic [31:0] resp_rdata;
    logic [29:0] addr_o;
    logic [3:0]  be_n_o;
    logic        ads_n_o, wr_o, dc_o, mio_o, lock_n_o, bus_oe_o, dout_oe_o, hlda_o;
    logic [31:0] dout_o;
    logic [31:0] din_i = '0;
    logic        rdy_n_i = 1'b1, nxt_n_i = 1'b1, sz16_n_i = 1'b1, hold_i = 1'b0;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    busctl_top u_dut (.*);

    typedef struct packed {
        logic [31:0] addr;
        logic [1:0]  size;
        logic        wr, dc, mem, sz16, err;
        logic [31:0] wdata, din1, din2, rdata;
        logic [3:0]  be_n, be2_n;
        logic [2:0]  waits;
    } vec_t;

    localparam vec_t VEC [10] = '{
        '{32'h0000_1000, 2'd3, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0,        32'hA1B2C3D4, 32'h0,        32'hA1B2C3D4, 4'h0, 4'hF, 3'd0},
        '{32'h0000_2001, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0,        32'hA1B2C3D4, 32'h0,        32'h0000C300, 4'hD, 4'hF, 3'd2},
        '{32'h0000_3002, 2'd1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 32'h11223344, 32'hA1B2C3D4, 32'h0,        32'h00000000, 4'h3, 4'hF, 3'd1},
        '{32'h0000_4001, 2'd2, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0,        32'hA1B2C3D4, 32'h0,        32'hA1B2C300, 4'h1, 4'hF, 3'd0},
        '{32'h0000_5003, 2'd1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 32'h0,        32'h0,        32'h0,        32'h00000000, 4'hF, 4'hF, 3'd0},
        '{32'h0000_6000, 2'd3, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 32'h0,        32'hA1B2C3D4, 32'h55667788, 32'h5566C3D4, 4'h0, 4'h3, 3'd1},
        '{32'h0000_7001, 2'd1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 32'h0,        32'hA1B2C3D4, 32'h55667788, 32'h0066C300, 4'h9, 4'hB, 3'd0},
        '{32'h0000_8000, 2'd1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 32'h0,        32'hA1B2C3D4, 32'h0,        32'h0000C3D4, 4'hC, 4'hF, 3'd0},
        '{32'h0000_9000, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 32'hDEADBEEF, 32'h0,        32'h0,        32'h00000000, 4'h0, 4'hF, 3'd0},
        '{32'h0000_A002, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0,        32'hA1B2C3D4, 32'h0,        32'h00B20000, 4'hB, 4'hF, 3'd3}
    };

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One transfer from idle, driven at negedges, ending at the response negedge.
    task automatic do_xfer(input vec_t v);
        logic [3:0] be_hold;
        req_valid = 1'b1; req_addr = v.addr; req_size = v.size; req_write = v.wr;
        req_data = v.dc; req_mem = v.mem; req_wdata = v.wdata;
        #1 chk(req_ack == 1'b1, "R3 ack in idle", 32'(req_ack), 32'd1);
        @(negedge clk);
        req_valid = 1'b0;
        if (v.err) begin
            chk(resp_valid && resp_err, "R2 misaligned error", {30'd0, resp_valid, resp_err}, 32'd3);
            chk(ads_n_o == 1'b1, "R2 no strobe", 32'(ads_n_o), 32'd1);
            chk(resp_rdata == 32'h0, "R2 error data", resp_rdata, 32'h0);
            return;
        end
        chk(ads_n_o == 1'b0, "R3 strobe", 32'(ads_n_o), 32'd0);
        chk(be_n_o == v.be_n, "R1 byte enables", 32'(be_n_o), 32'(v.be_n));
        chk(addr_o == v.addr[31:2], "R1 word address", 32'(addr_o), 32'(v.addr[31:2]));
        chk({wr_o, dc_o, mio_o} == {v.wr, v.dc, v.mem}, "R5 cycle definition",
            32'({wr_o, dc_o, mio_o}), 32'({v.wr, v.dc, v.mem}));
        chk(dout_oe_o == v.wr, "R12 data drive", 32'(dout_oe_o), 32'(v.wr));
        if (v.wr) chk(dout_o == v.wdata, "R12 write data", dout_o, v.wdata);
        be_hold = be_n_o;
        @(negedge clk);
        for (int w = 0; w < int'(v.waits); w++) begin
            @(negedge clk);
            chk(!resp_valid && ads_n_o && (be_n_o == be_hold), "R4 wait state",
                {27'd0, resp_valid, ads_n_o, be_n_o}, {27'd0, 1'b0, 1'b1, be_hold});
        end
        rdy_n_i = 1'b0; din_i = v.din1; sz16_n_i = !v.sz16;
        @(negedge clk);
        rdy_n_i = 1'b1; sz16_n_i = 1'b1;
        if (v.be2_n != 4'hF) begin
            chk(ads_n_o == 1'b0 && !resp_valid, "R7 second strobe", {30'd0, ads_n_o, resp_valid}, 32'd0);
            chk(be_n_o == v.be2_n, "R7 upper enables", 32'(be_n_o), 32'(v.be2_n));
            @(negedge clk);
            rdy_n_i = 1'b0; din_i = v.din2;
            @(negedge clk);
            rdy_n_i = 1'b1;
        end
        chk(resp_valid && !resp_err, "R3 response", {30'd0, resp_valid, resp_err}, 32'd2);
        chk(resp_rdata == v.rdata, "R8 read data", resp_rdata, v.rdata);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk(ads_n_o && be_n_o == 4'hF && !hlda_o && lock_n_o && !resp_valid && bus_oe_o,
            "R11 reset state", {24'd0, ads_n_o, be_n_o, hlda_o, lock_n_o, resp_valid},
            {24'd0, 1'b1, 4'hF, 1'b0, 1'b1, 1'b0});

        for (int i = 0; i < 10; i++) do_xfer(VEC[i]);

        // R9 hold beats a pending request; bus floats.
        req_valid = 1'b1; req_addr = 32'h100; req_size = 2'd3; req_write = 1'b1; req_wdata = 32'h12345678;
        hold_i = 1'b1;
        #1 chk(req_ack == 1'b0, "R9 hold priority", 32'(req_ack), 32'd0);
        @(negedge clk);
        req_valid = 1'b0;
        chk(hlda_o && !bus_oe_o && !dout_oe_o && ads_n_o, "R9 bus released",
            {28'd0, hlda_o, bus_oe_o, dout_oe_o, ads_n_o}, {28'd0, 4'b1001});
        repeat (2) @(negedge clk);
        chk(hlda_o == 1'b1, "R9 grant held", 32'(hlda_o), 32'd1);
        hold_i = 1'b0;
        @(negedge clk);
        chk(hlda_o == 1'b0, "R9 grant released", 32'(hlda_o), 32'd0);

        // R10 locked sequence blocks hold until an unlocked request.
        req_lock = 1'b1;
        do_xfer(VEC[0]);
        chk(lock_n_o == 1'b0, "R10 lock asserted", 32'(lock_n_o), 32'd0);
        hold_i = 1'b1;
        req_lock = 1'b0;
        repeat (3) @(negedge clk);
        chk(hlda_o == 1'b0 && lock_n_o == 1'b0, "R10 hold blocked while locked",
            {30'd0, hlda_o, lock_n_o}, 32'd0);
        do_xfer(VEC[3]);
        chk(lock_n_o == 1'b1, "R10 lock released", 32'(lock_n_o), 32'd1);
        @(negedge clk);
        chk(hlda_o == 1'b1, "R10 hold after unlock", 32'(hlda_o), 32'd1);
        hold_i = 1'b0;
        @(negedge clk);

        // R6 pipelined address.
        req_valid = 1'b1; req_addr = 32'h0000_0100; req_size = 2'd1; req_write = 1'b0;
        req_data = 1'b1; req_mem = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        req_valid = 1'b1; req_addr = 32'h0000_0204; req_size = 2'd3; req_write = 1'b1;
        req_wdata = 32'hCAFEF00D; nxt_n_i = 1'b0;
        #1 chk(req_ack == 1'b1, "R6 early accept", 32'(req_ack), 32'd1);
        @(negedge clk);
        req_valid = 1'b0; nxt_n_i = 1'b1;
        chk(ads_n_o == 1'b0 && addr_o == 30'h81 && wr_o && !resp_valid, "R6 early address",
            {ads_n_o, resp_valid, addr_o}, {1'b0, 1'b0, 30'h81});
        chk(dout_oe_o == 1'b0, "R6 current read keeps data off", 32'(dout_oe_o), 32'd0);
        rdy_n_i = 1'b0; din_i = 32'h0BADCAFE;
        @(negedge clk);
        chk(resp_valid && resp_rdata == 32'h0000CAFE, "R6 first done", resp_rdata, 32'h0000CAFE);
        chk(ads_n_o && dout_oe_o && dout_o == 32'hCAFEF00D, "R6 next data phase", dout_o, 32'hCAFEF00D);
        @(negedge clk);
        rdy_n_i = 1'b1;
        chk(resp_valid && resp_rdata == 32'h0, "R6 second done", resp_rdata, 32'h0);

        // R6 refusal when the current transfer could still be split.
        req_valid = 1'b1; req_addr = 32'h0000_0300; req_size = 2'd3; req_write = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        req_valid = 1'b1; req_addr = 32'h0000_0400; nxt_n_i = 1'b0;
        #1 chk(req_ack == 1'b0, "R6 refused on split risk", 32'(req_ack), 32'd0);
        req_valid = 1'b0; nxt_n_i = 1'b1;
        @(negedge clk);
        chk(ads_n_o == 1'b1, "R6 no early strobe", 32'(ads_n_o), 32'd1);
        rdy_n_i = 1'b0; din_i = 32'h01020304;
        @(negedge clk);
        rdy_n_i = 1'b1;
        chk(resp_valid && resp_rdata == 32'h01020304, "R8 full word", resp_rdata, 32'h01020304);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule